// File: doc/BRIEF.md
# Slow Host Bus Write Bridge

This block watches the memory bus of an 8-bit processor that runs on a slow host clock. It picks out memory write cycles that land in a 512 KB window and turns each one into a single write request in a much faster memory clock domain. Each request is a one-cycle write enable with a 19-bit memory address and an 8-bit data byte.

Only the three bus strobes that classify a cycle pass through the block's synchronisers: the opcode-fetch marker, the memory-request marker and the write marker. Address and data are taken directly from the bus. They are sampled in the fast domain in the cycle that detects the write, when the slow bus has held them stable for several fast cycles. A write enable rises once for each bus write cycle, however long the processor holds its strobes. A new write is only accepted after the strobes go inactive again. This lets one slow cycle drive a fast memory port without running that port at the processor's rate. Each write reaches memory a few fast cycles after its strobes assert, well before the processor can start its next read.

Top module: `host_write_bridge`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `mem_we` is low. Reset clears `mem_addr` and `mem_wdata` to zero and returns the strobe synchronisers to the inactive (high) level.
- R2: A qualifying bus write raises `mem_we` for exactly one fast cycle. With strobes asserted just after one rising edge, `mem_we` is high after the third rising edge and low again after the fourth.
- R3: In the cycle where `mem_we` is high, `mem_addr` equals `bus_addr[18:0]` and `mem_wdata` equals `bus_data` of the write.
- R4: A write qualifies only if `bus_addr[21:19]` equals 3'b011. Other values of those bits give no pulse.
- R5: A write cycle with `bus_m1_n` low (opcode fetch) gives no pulse.
- R6: A write cycle with `bus_mreq_n` high (not a memory request) gives no pulse.
- R7: While the strobes stay asserted, only one pulse is produced, even if the address changes. A later write gives a new pulse only after `bus_wr_n` or `bus_mreq_n` has returned high.
- R8: `mem_addr` and `mem_wdata` keep their values in every cycle where `mem_we` is low.
- R9: The window edges 0x180000 and 0x1FFFFF are accepted. The neighbours 0x17FFFF and 0x200000 are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast memory clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 22 | Processor address bus |
| bus_data | input | 8 | Processor write data |
| bus_m1_n | input | 1 | Opcode-fetch marker, active low |
| bus_mreq_n | input | 1 | Memory request, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| mem_we | output | 1 | One-cycle write enable to memory |
| mem_addr | output | 19 | Memory word address |
| mem_wdata | output | 8 | Memory write data |

## Verification
A table of bus cycles is applied, each with different combinations of address, opcode-fetch marker and request marker:
- In-window addresses confirm that the address offset and the data byte are forwarded.
- The four window-edge addresses locate the decode boundary exactly.
- Out-of-window writes, an opcode-fetch write and a non-memory write must each leave the write enable and the held outputs unchanged.

A long-held write cycle with a changing address separates edge detection from level detection, and a second write after release shows that the bridge re-arms. Pulse timing is checked against the exact synchroniser latency.

// File: rtl/hbw_pkg.sv
package hbw_pkg;
  localparam int BUS_AW_DEF  = 22;
  localparam int MEM_AW_DEF  = 19;
  localparam int DATA_W_DEF  = 8;
  localparam int SYNC_N_DEF  = 2;
  localparam int TAG_W_DEF   = BUS_AW_DEF - MEM_AW_DEF;
  localparam logic [TAG_W_DEF-1:0] WIN_TAG_DEF = 3'b011;

  // bit order of the synchronised strobe vector
  localparam int STB_M1   = 2;
  localparam int STB_MREQ = 1;
  localparam int STB_WR   = 0;
  localparam int STB_W    = 3;
endpackage

// File: rtl/hbw_sync.sv
module hbw_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

  // R1: stages return to the idle level after reset
  a_r1_sync_idle: assert property (@(posedge clk) rst |=> (q == RST_VAL));
endmodule

// File: rtl/hbw_window.sv
module hbw_window #(
  parameter int BUS_AW = 22,
  parameter int MEM_AW = 19,
  parameter logic [BUS_AW-MEM_AW-1:0] TAG = 3'b011
) (
  input  logic [BUS_AW-1:0] addr,
  output logic              hit,
  output logic [MEM_AW-1:0] offs
);
  localparam int TAG_W = BUS_AW - MEM_AW;
  logic [TAG_W-1:0] tag_bits;

  assign tag_bits = addr[BUS_AW-1:MEM_AW];
  assign hit      = (tag_bits == TAG);
  assign offs     = addr[MEM_AW-1:0];
endmodule

// File: rtl/hbw_pulse.sv
module hbw_pulse #(
  parameter int MEM_AW = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              qual,
  input  logic              hit,
  input  logic [MEM_AW-1:0] offs,
  input  logic [DATA_W-1:0] data,
  output logic              we,
  output logic [MEM_AW-1:0] addr,
  output logic [DATA_W-1:0] wdata
);
  logic qual_q;
  logic fire;

  assign fire = qual & ~qual_q & hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      qual_q <= 1'b0;
      we     <= 1'b0;
      addr   <= '0;
      wdata  <= '0;
    end else begin
      qual_q <= qual;
      we     <= fire;
      if (fire) begin
        addr  <= offs;
        wdata <= data;
      end
    end
  end

  // R1: enable low after reset
  a_r1_we_low: assert property (@(posedge clk) rst |=> !we);
  // R2 / R7: a pulse lasts one cycle
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (rst) we |=> !we);
  // R8: outputs hold when no write is issued
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !we |-> ($stable(addr) && $stable(wdata)));
endmodule

// File: rtl/host_write_bridge.sv
module host_write_bridge
  import hbw_pkg::*;
#(
  parameter int BUS_AW = BUS_AW_DEF,
  parameter int MEM_AW = MEM_AW_DEF,
  parameter int DATA_W = DATA_W_DEF,
  parameter int SYNC_N = SYNC_N_DEF,
  parameter logic [BUS_AW-MEM_AW-1:0] WIN_TAG = WIN_TAG_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_m1_n,
  input  logic              bus_mreq_n,
  input  logic              bus_wr_n,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int LAT = SYNC_N + 1;

  logic [STB_W-1:0]  stb_raw;
  logic [STB_W-1:0]  stb_s;
  logic              qual;
  logic              hit;
  logic [MEM_AW-1:0] offs;

  always_comb begin
    stb_raw           = '1;
    stb_raw[STB_M1]   = bus_m1_n;
    stb_raw[STB_MREQ] = bus_mreq_n;
    stb_raw[STB_WR]   = bus_wr_n;
  end

  hbw_sync #(.W(STB_W), .STAGES(SYNC_N), .RST_VAL({STB_W{1'b1}})) u_sync (
    .clk(clk), .rst(rst), .d(stb_raw), .q(stb_s)
  );

  assign qual = stb_s[STB_M1] & ~stb_s[STB_MREQ] & ~stb_s[STB_WR];

  hbw_window #(.BUS_AW(BUS_AW), .MEM_AW(MEM_AW), .TAG(WIN_TAG)) u_win (
    .addr(bus_addr), .hit(hit), .offs(offs)
  );

  hbw_pulse #(.MEM_AW(MEM_AW), .DATA_W(DATA_W)) u_pulse (
    .clk(clk), .rst(rst), .qual(qual), .hit(hit), .offs(offs), .data(bus_data),
    .we(mem_we), .addr(mem_addr), .wdata(mem_wdata)
  );

  // R4 / R9: a pulse follows an address inside the window
  a_r4_window_only: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(bus_addr[BUS_AW-1:MEM_AW]) == WIN_TAG));
  // R5 / R6: the strobes seen LAT cycles earlier formed a memory write
  a_r5_write_kind: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(bus_m1_n, 3) && !$past(bus_mreq_n, 3) && !$past(bus_wr_n, 3)));
  // R3: forwarded offset matches the bus at the detection cycle
  a_r3_addr_fwd: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr == $past(bus_addr[MEM_AW-1:0])));

  initial begin
    a_lat_cfg: assert (LAT == 3);
  end
endmodule

// File: tb/host_write_bridge_test.sv
module host_write_bridge_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [21:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        bus_m1_n = 1'b1;
  logic        bus_mreq_n = 1'b1;
  logic        bus_wr_n = 1'b1;
  logic        mem_we;
  logic [18:0] mem_addr;
  logic [7:0]  mem_wdata;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  bit done = 0;

  always #10 clk = ~clk;

  host_write_bridge uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_m1_n(bus_m1_n), .bus_mreq_n(bus_mreq_n), .bus_wr_n(bus_wr_n),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always @(negedge clk) if (mem_we === 1'b1) pulses++;

  // {addr[21:0], data[7:0], m1_n, mreq_n, expect_pulse}
  localparam logic [32:0] VEC [10] = '{
    {22'h1A5A5A, 8'h3C, 3'b101},  // R2 R3 mid window
    {22'h180000, 8'h01, 3'b101},  // R9 low edge
    {22'h1FFFFF, 8'hFF, 3'b101},  // R9 high edge
    {22'h17FFFF, 8'h55, 3'b100},  // R9 below
    {22'h200000, 8'hAA, 3'b100},  // R9 above
    {22'h000123, 8'h11, 3'b100},  // R4 tag 000
    {22'h3C0000, 8'h22, 3'b100},  // R4 tag 111
    {22'h1C0001, 8'h33, 3'b000},  // R5 opcode fetch
    {22'h1C0002, 8'h44, 3'b110},  // R6 no memory request
    {22'h1B0003, 8'h99, 3'b101}   // R2 R3 second data
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [21:0] a, input logic [7:0] d, input logic m1, input logic mreq);
    @(negedge clk);
    bus_addr = a; bus_data = d; bus_m1_n = m1; bus_mreq_n = mreq; bus_wr_n = 1'b0;
  endtask

  task automatic release_bus();
    @(negedge clk);
    bus_wr_n = 1'b1; bus_mreq_n = 1'b1; bus_m1_n = 1'b1;
    repeat (5) @(posedge clk);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [18:0] last_addr;
    logic [7:0]  last_data;
    int p0;

    // R1: reset state, and a write seen during reset is dropped
    repeat (3) @(posedge clk);
    #1;
    chk("R1 we in reset", mem_we, 0);
    chk("R1 addr reset", mem_addr, 0);
    chk("R1 data reset", mem_wdata, 0);
    drive(22'h190000, 8'h5A, 1'b1, 1'b0);
    repeat (6) @(posedge clk);
    #1;
    chk("R1 no pulse in reset", pulses, 0);
    @(negedge clk);
    bus_wr_n = 1'b1; bus_mreq_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 idle after reset", pulses, 0);

    last_addr = '0;
    last_data = '0;
    for (int i = 0; i < 10; i++) begin
      logic [21:0] a;
      logic [7:0]  d;
      logic        ex;
      a  = VEC[i][32:11];
      d  = VEC[i][10:3];
      ex = VEC[i][0];
      p0 = pulses;
      drive(a, d, VEC[i][2], VEC[i][1]);
      repeat (3) @(posedge clk);
      #1;
      chk("R2/R4/R5/R6/R9 we at latency", mem_we, ex);
      if (ex) begin
        chk("R3 address", mem_addr, a[18:0]);
        chk("R3 data", mem_wdata, d);
        last_addr = a[18:0];
        last_data = d;
      end else begin
        chk("R8 address held", mem_addr, last_addr);
        chk("R8 data held", mem_wdata, last_data);
      end
      @(posedge clk);
      #1;
      chk("R2 pulse one cycle", mem_we, 0);
      release_bus();
      chk("R2 pulse count", pulses - p0, ex);
    end

    // R7: long held strobe, address moves, single pulse
    p0 = pulses;
    drive(22'h190010, 8'h77, 1'b1, 1'b0);
    repeat (10) @(posedge clk);
    @(negedge clk) bus_addr = 22'h190020;
    repeat (20) @(posedge clk);
    #1;
    chk("R7 one pulse while held", pulses - p0, 1);
    chk("R7 first address kept", mem_addr, 19'h10010);
    release_bus();
    drive(22'h190020, 8'h78, 1'b1, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    chk("R7 rearmed pulse", mem_we, 1);
    chk("R7 rearmed address", mem_addr, 19'h10020);
    release_bus();
    chk("R7 total pulses", pulses - p0, 2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule